// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is the host-control slave of a video receiver. It watches an I2C bus and answers at a 7-bit device address. It turns bus writes into writes on a byte-wide register port, and it serves bus reads from the same port. Both bus lines pass through a synchronizer and a glitch filter that runs on the system clock. Start, stop, bit and byte timing are then decoded from the filtered lines. The map behind the port is not part of this block. The block shows the map a pointer, a write strobe and write data, and it reads the map's combinational read data back.

The first data byte of a write transaction loads the register pointer. Each later byte is written at the pointer, and the pointer then advances by one. A read returns the byte at the pointer and advances the pointer. The read continues while the master acknowledges and ends when the master does not acknowledge. An active-low chip select gates the whole state machine. While it is high, the block returns to idle and leaves SDA released.

The device address starts at the default (write byte 0x98). The address never changes at reset. It moves to the alternate address (write byte 0x9A) only when software writes the sample command to the control pointer and a pull-up is then read on the strap pin. That pin normally carries a sync output. To read it, the block disables the pin's output driver for a short window and captures the pad at the end of that window.

Top module: `i2c_strap_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), `reg_we_o` is 0, the strap pin's driver is enabled (`strap_oe_o`=1), and the device answers at 7-bit address 0x4C (write byte 0x98, read byte 0x99).
- R2: An address byte whose upper seven bits equal the current device address is acknowledged by pulling SDA low during the ninth clock. A non-matching address is not acknowledged, and SDA stays released for all further clocks until the next start condition.
- R3: In a write transaction, the first byte after the address loads the register pointer. Each further byte produces a one-cycle `reg_we_o` pulse with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte, and the pointer then increments by one. Every byte is acknowledged.
- R4: In a read transaction, the block sends the byte at the current pointer MSB first and increments the pointer after each byte. An acknowledge from the master makes it send the next byte.
- R5: A not-acknowledge from the master after a read byte ends the transaction. SDA stays released until the next start condition.
- R6: While `cs_ni` is high, no address is acknowledged, no register write occurs and any transaction in progress is abandoned. A transaction needs a new start condition after `cs_ni` returns low.
- R7: A write to pointer 0xFF with data bit 0 set is the sample command. The cycle after the resulting `reg_we_o` pulse, `strap_oe_o` drops for exactly 2 cycles, and the pad is captured on the second of them. If the pad reads 1, the device address becomes 0x4D (write byte 0x9A). If it reads 0, the address becomes 0x4C.
- R8: The device address changes only through the sample command. A write to 0xFF with bit 0 clear opens no strap window and leaves the address as it was. Reset restores 0x4C.
- R9: A high pulse on SCL shorter than the filter length (4 system clocks) is ignored and corrupts no transfer.
- R10: A repeated start condition in the middle of a transaction restarts the address phase, with the pointer kept.
- R11: A stop condition returns the block to idle with SDA released. Bits clocked after the stop without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select; high blocks all bus activity |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| sync_i | input | 1 | Internal sync signal routed to the shared strap pin |
| strap_pad_i | input | 1 | Level read back from the shared strap pin |
| strap_o | output | 1 | Value driven on the shared strap pin |
| strap_oe_o | output | 1 | Output enable of the shared strap pin |
| reg_addr_o | output | PTR_W | Register pointer presented to the map |
| reg_wdata_o | output | 8 | Write data for the map |
| reg_we_o | output | 1 | One-cycle write strobe to the map |
| reg_rdata_i | input | 8 | Combinational read data from the map at `reg_addr_o` |

## Verification
The sample command is both an ordinary map write and the trigger of the strap window, so these two events land in adjacent cycles. The bench writes 0x01 to pointer 0xFF while the pull-up and the sync level differ. It records the cycle of the `reg_we_o` pulse and the first cycle in which `strap_oe_o` is low, and it requires exactly one cycle between them. It also requires the window to last exactly two cycles and the map to receive the write. Address probes afterwards confirm that the value captured is the pull-up level, not the driven sync level.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } slv_state_e;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } byte_kind_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned N_LINES     = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] clean_o
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   clean_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q  <= '1;
        hist_q  <= '1;
        clean_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[g]};
        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
        // level changes only after FILT_LEN identical samples
        if (&hist_q)       clean_q <= 1'b1;
        else if (~|hist_q) clean_q <= 1'b0;
      end
    end

    assign clean_o[g] = clean_q;
  end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pad_i,
  output logic oe_o,
  output logic cap_o,
  output logic alt_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          alt_q;

  assign cap_o = (cnt_q == CW'(1));
  assign oe_o  = (cnt_q == '0);
  assign alt_o = alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      alt_q <= 1'b0;
    end else begin
      if (trig_i)           cnt_q <= CW'(HOLD_CYC);
      else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      // driver has been off for HOLD_CYC-1 cycles here
      if (cap_o) alt_q <= pad_i;
    end
  end

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave
  import i2c_strap_pkg::*;
#(
  parameter logic [6:0]  DEF_ADDR    = 7'h4C,
  parameter logic [6:0]  ALT_ADDR    = 7'h4D,
  parameter int unsigned PTR_W       = 8,
  parameter logic [7:0]  CTRL_PTR    = 8'hFF,
  parameter int unsigned SAMPLE_BIT  = 0,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  parameter int unsigned HOLD_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              sync_i,
  input  logic              strap_pad_i,
  output logic              strap_o,
  output logic              strap_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  localparam int unsigned BIT_CW = $clog2(BYTE_W + 1);

  logic [1:0] raw_lines, clean_lines;
  logic       scl_f, sda_f;
  logic       start_p, stop_p, scl_rise, scl_fall;
  logic [SYNC_STAGES-1:0] cs_q;
  logic       cs_act;
  logic       alt_sel, cap_en;
  logic [6:0] dev_addr;

  slv_state_e        state_q;
  byte_kind_e        kind_q;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q, tx_q, wdata_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              rw_q, oe_q, we_q, trig_q, mack_q;

  assign raw_lines = {sda_i, scl_i};
  assign scl_f     = clean_lines[0];
  assign sda_f     = clean_lines[1];

  i2c_line_filter #(
    .N_LINES    (2),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_lines),
    .clean_o(clean_lines)
  );

  i2c_bus_events u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_f),
    .sda_i  (sda_f),
    .start_o(start_p),
    .stop_o (stop_p),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  strap_sampler #(
    .HOLD_CYC(HOLD_CYC)
  ) u_strap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_q),
    .pad_i (strap_pad_i),
    .oe_o  (strap_oe_o),
    .cap_o (cap_en),
    .alt_o (alt_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= '1;
    else         cs_q <= {cs_q[SYNC_STAGES-2:0], cs_ni};
  end

  assign cs_act   = ~cs_q[SYNC_STAGES-1];
  assign dev_addr = alt_sel ? ALT_ADDR : DEF_ADDR;
  assign strap_o  = sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= BK_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      wdata_q   <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      trig_q    <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      trig_q <= 1'b0;
      // pointer advances the cycle after a write strobe
      if (we_q) ptr_q <= ptr_q + PTR_W'(1);

      if (!cs_act) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_p) begin
        state_q   <= ST_RX;
        kind_q    <= BK_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_p) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
            end else if (scl_fall && bit_cnt_q == BIT_CW'(BYTE_W)) begin
              bit_cnt_q <= '0;
              unique case (kind_q)
                BK_ADDR: begin
                  if (shreg_q[7:1] == dev_addr) begin
                    rw_q    <= shreg_q[0];
                    state_q <= ST_ACK;
                    oe_q    <= 1'b1;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                BK_PTR: begin
                  ptr_q   <= shreg_q[PTR_W-1:0];
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
                default: begin
                  we_q    <= 1'b1;
                  wdata_q <= shreg_q;
                  trig_q  <= (BYTE_W'(ptr_q) == CTRL_PTR) && shreg_q[SAMPLE_BIT];
                  state_q <= ST_ACK;
                  oe_q    <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (kind_q == BK_ADDR && rw_q) begin
                tx_q    <= reg_rdata_i;
                ptr_q   <= ptr_q + PTR_W'(1);
                oe_q    <= ~reg_rdata_i[BYTE_W-1];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
                kind_q  <= (kind_q == BK_ADDR) ? BK_PTR : BK_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt_q == BIT_CW'(BYTE_W - 1)) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                tx_q      <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q      <= ~tx_q[BYTE_W-2];
                bit_cnt_q <= bit_cnt_q + BIT_CW'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                tx_q      <= reg_rdata_i;
                ptr_q     <= ptr_q + PTR_W'(1);
                oe_q      <= ~reg_rdata_i[BYTE_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = we_q;

endmodule

// File: rtl/i2c_strap_slave_chk.sv
module i2c_strap_slave_chk #(
  parameter int unsigned HOLD_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic strap_oe_o,
  input logic cap_en,
  input logic alt_sel,
  input logic stop_p
);

  logic [7:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             low_cnt_q <= '0;
    else if (strap_oe_o)                     low_cnt_q <= '0;
    else if (low_cnt_q != 8'hFF)             low_cnt_q <= low_cnt_q + 8'd1;
  end

  AST_CS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_act |=> !sda_oe_o); // R6
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni) reg_we_o |=> !reg_we_o); // R3
  AST_STRAP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni) low_cnt_q <= 8'(HOLD_CYC)); // R7
  AST_CAP_DRIVER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_en |-> !strap_oe_o); // R7
  AST_ADDR_ONLY_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(alt_sel) |-> $past(cap_en)); // R8
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni) stop_p |=> !sda_oe_o); // R11

endmodule

bind i2c_strap_slave i2c_strap_slave_chk #(
  .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_act    (cs_act),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .strap_oe_o(strap_oe_o),
  .cap_en    (cap_en),
  .alt_sel   (alt_sel),
  .stop_p    (stop_p)
);

// File: tb/i2c_strap_slave_bench.sv
module i2c_strap_slave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;
  localparam int WD_LIMIT   = 150000;

  logic clk = 1'b0;
  logic rst_n, cs_n, scl_m, sda_m, sync_v, pull_v;
  logic sda_oe, strap_o, strap_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic line, strap_pad;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [256];
  bit   init_done;
  int   wr_count = 0;
  int   cyc = 0;
  int   run = 0, last_run = 0, run_total = 0, first_low_cyc = 0;
  int   ctrl_we_cyc = 0;
  bit   quiet_win = 1'b0;
  int   quiet_hits = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign line      = sda_m & ~sda_oe;
  assign strap_pad = strap_oe ? strap_o : pull_v;
  assign reg_rdata = mem[reg_addr];

  i2c_strap_slave u_i2c_strap_slave (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cs_ni      (cs_n),
    .scl_i      (scl_m),
    .sda_i      (line),
    .sda_oe_o   (sda_oe),
    .sync_i     (sync_v),
    .strap_pad_i(strap_pad),
    .strap_o    (strap_o),
    .strap_oe_o (strap_oe),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_rdata_i(reg_rdata)
  );

  // register map model
  always @(posedge clk) begin
    if (!init_done) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      init_done <= 1'b1;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wr_count      <= wr_count + 1;
    end
  end

  // monitor and watchdog
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!strap_oe) begin
        if (run == 0) first_low_cyc <= cyc;
        run <= run + 1;
      end else if (run > 0) begin
        last_run  <= run;
        run_total <= run_total + 1;
        run       <= 0;
      end
      if (reg_we && reg_addr == 8'hFF) ctrl_we_cyc <= cyc;
      if (quiet_win && sda_oe) quiet_hits <= quiet_hits + 1;
    end
    if (cyc > WD_LIMIT) begin
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic clk_bit(input logic b, input bit glitch, output logic seen);
    sda_m = b;
    if (glitch) begin
      tick(5); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(Q - 7);
    end else begin
      tick(Q);
    end
    scl_m = 1'b1; tick(Q);
    seen  = line;
    scl_m = 1'b0; tick(2);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], glitch, s);
    clk_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic get_byte(input bit master_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    clk_bit(~master_ack, 1'b0, s);
  endtask

  task automatic probe_addr(input logic [7:0] ab, output logic ack);
    bus_start();
    put_byte(ab, 1'b0, ack);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(5);
    rst_n = 1'b1; tick(5);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);
    chk(reg_we == 1'b0, "R1", "reg_we after reset", int'(reg_we), 0);
    chk(strap_oe == 1'b1, "R1", "strap_oe after reset", int'(strap_oe), 1);
  endtask

  task automatic t_write();
    logic a0, a1, a2, a3;
    int w0;
    w0 = wr_count;
    bus_start();
    put_byte(8'h98, 1'b0, a0);
    put_byte(8'h10, 1'b0, a1);
    put_byte(8'h3C, 1'b0, a2);
    put_byte(8'hC3, 1'b0, a3);
    bus_stop();
    chk(a0, "R1", "ack at default write byte 98", int'(a0), 1);
    chk(a1 && a2 && a3, "R3", "acks on pointer and data", int'({a1, a2, a3}), 7);
    chk(mem[8'h10] == 8'h3C, "R3", "mem[10]", int'(mem[8'h10]), 'h3C);
    chk(mem[8'h11] == 8'hC3, "R3", "mem[11] after increment", int'(mem[8'h11]), 'hC3);
    chk(wr_count - w0 == 2, "R3", "write strobes", wr_count - w0, 2);
  endtask

  task automatic t_read();
    logic a0, a1, a2;
    logic [7:0] b0, b1, b2;
    int q0;
    bus_start();
    put_byte(8'h98, 1'b0, a0);
    put_byte(8'h10, 1'b0, a1);
    bus_start();
    put_byte(8'h99, 1'b0, a2);
    chk(a2, "R10", "ack on read byte after repeated start", int'(a2), 1);
    get_byte(1'b1, b0);
    get_byte(1'b1, b1);
    get_byte(1'b0, b2);
    chk(b0 == 8'h3C, "R4", "read byte 0", int'(b0), 'h3C);
    chk(b1 == 8'hC3, "R4", "read byte 1", int'(b1), 'hC3);
    chk(b2 == (8'h12 ^ 8'h5A), "R4", "read byte 2", int'(b2), 'h12 ^ 'h5A);
    q0 = quiet_hits;
    quiet_win = 1'b1;
    put_byte(8'h00, 1'b0, a0);
    quiet_win = 1'b0;
    bus_stop();
    chk(quiet_hits == q0, "R5", "SDA pulled after NACK", quiet_hits - q0, 0);
  endtask

  task automatic t_nomatch();
    logic a0;
    int q0;
    bus_start();
    put_byte(8'hA0, 1'b0, a0);
    chk(!a0, "R2", "ack on foreign address", int'(a0), 0);
    q0 = quiet_hits;
    quiet_win = 1'b1;
    put_byte(8'h00, 1'b0, a0);
    put_byte(8'h98, 1'b0, a0);
    quiet_win = 1'b0;
    bus_stop();
    chk(quiet_hits == q0, "R2", "SDA pulled before next start", quiet_hits - q0, 0);
  endtask

  task automatic t_chip_select();
    logic a0, a1, a2;
    int w0;
    w0 = wr_count;
    cs_n = 1'b1; tick(5);
    bus_start();
    put_byte(8'h98, 1'b0, a0);
    put_byte(8'h20, 1'b0, a1);
    put_byte(8'h77, 1'b0, a2);
    bus_stop();
    chk(!a0, "R6", "ack with chip select high", int'(a0), 0);
    cs_n = 1'b0; tick(5);
    bus_start();
    put_byte(8'h98, 1'b0, a0);
    cs_n = 1'b1;
    put_byte(8'h20, 1'b0, a1);
    put_byte(8'h77, 1'b0, a2);
    cs_n = 1'b0;
    put_byte(8'h66, 1'b0, a2);
    bus_stop();
    chk(a0 && !a1, "R6", "ack pattern across chip select rise", int'({a0, a1}), 2);
    chk(!a2, "R6", "ack after chip select returns without start", int'(a2), 0);
    chk(wr_count == w0, "R6", "writes with chip select high", wr_count - w0, 0);
  endtask

  task automatic t_glitch();
    logic a0, a1, a2;
    bus_start();
    put_byte(8'h98, 1'b1, a0);
    put_byte(8'h40, 1'b1, a1);
    put_byte(8'hA5, 1'b1, a2);
    bus_stop();
    chk(a0 && a1 && a2, "R9", "acks with SCL glitches", int'({a0, a1, a2}), 7);
    chk(mem[8'h40] == 8'hA5, "R9", "mem[40] with SCL glitches", int'(mem[8'h40]), 'hA5);
  endtask

  task automatic t_sample(input logic pad_level, input logic [7:0] data, input bit expect_window,
                          input logic [7:0] cur_wr);
    logic a0, a1, a2;
    int r0;
    r0 = run_total;
    pull_v = pad_level;
    sync_v = ~pad_level;
    bus_start();
    put_byte(cur_wr, 1'b0, a0);
    put_byte(8'hFF, 1'b0, a1);
    put_byte(data, 1'b0, a2);
    bus_stop();
    chk(a0 && a1 && a2, expect_window ? "R7" : "R8", "acks on control write", int'({a0, a1, a2}), 7);
    chk(mem[8'hFF] == data, "R7", "control write reaches map", int'(mem[8'hFF]), int'(data));
    if (expect_window) begin
      chk(run_total - r0 == 1, "R7", "strap windows opened", run_total - r0, 1);
      chk(last_run == 2, "R7", "strap window length", last_run, 2);
      chk(first_low_cyc - ctrl_we_cyc == 1, "R7", "window start after write strobe",
          first_low_cyc - ctrl_we_cyc, 1);
    end else begin
      chk(run_total == r0, "R8", "strap window without sample bit", run_total - r0, 0);
    end
    sync_v = 1'b0;
  endtask

  task automatic t_stop();
    logic a0;
    bus_start();
    put_byte(8'h98, 1'b0, a0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11", "sda_oe after stop", int'(sda_oe), 0);
    put_byte(8'h98, 1'b0, a0);
    chk(!a0, "R11", "ack without start after stop", int'(a0), 0);
    bus_stop();
  endtask

  initial begin
    logic ack;
    rst_n = 1'b0; cs_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; sync_v = 1'b0; pull_v = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write();
    t_read();
    t_nomatch();
    t_chip_select();
    t_glitch();
    t_stop();
    // sample with pull-down: address remains default
    t_sample(1'b0, 8'h01, 1'b1, 8'h98);
    probe_addr(8'h98, ack);
    chk(ack, "R7", "98 after sample of low pad", int'(ack), 1);
    probe_addr(8'h9A, ack);
    chk(!ack, "R7", "9A after sample of low pad", int'(ack), 0);
    // control write without sample bit, pull-up present
    t_sample(1'b1, 8'h02, 1'b0, 8'h98);
    probe_addr(8'h9A, ack);
    chk(!ack, "R8", "9A without sample command", int'(ack), 0);
    // sample with pull-up: move to alternate address
    t_sample(1'b1, 8'h01, 1'b1, 8'h98);
    probe_addr(8'h9A, ack);
    chk(ack, "R7", "9A after sample of high pad", int'(ack), 1);
    probe_addr(8'h98, ack);
    chk(!ack, "R7", "98 after sample of high pad", int'(ack), 0);
    do_reset();
    probe_addr(8'h98, ack);
    chk(ack, "R8", "98 after reset", int'(ack), 1);
    probe_addr(8'h9A, ack);
    chk(!ack, "R8", "9A after reset", int'(ack), 0);
    tick(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule